// File: doc/BRIEF.md
# External Request-Handshake Drain Channel

This block moves words from an internal FIFO to an off-chip device in burst mode. Each word is handed over by a request/acknowledge handshake. Software starts the channel and loads a word budget at the same time. From then on, every cycle in which the device requests, the FIFO has a word and the channel is running moves exactly one word. In that cycle the block raises acknowledge and write strobe, presents the word on the data output and pops the FIFO.

Three events end a run:
- a software stop,
- a word that carries the end-of-packet marker,
- the word budget running out.

All three share one interrupt, which pulses when the channel goes idle. A status word shows the run bit and three sticky bits that tell which of the causes occurred. The sticky bits stay set until the next start. A dropped device request does not end a run: it only holds the transfer back until the request returns.

Top module: `xdma_drain`

## Requirements
- R1: After reset the status word is zero, the interrupt is low and acknowledge, write strobe and FIFO pop are low.
- R2: A start pulse while idle sets the run bit (status bit 0), clears the three cause bits and loads the word budget from the load input in the same clock edge. A start pulse while running is ignored and does not reload the budget.
- R3: Acknowledge, write strobe and FIFO pop are high in exactly the cycles where the channel runs, the device request is high and the FIFO is non-empty. In those cycles the data output equals the FIFO word. In no other cycle is a word moved.
- R4: While the device request is low the channel keeps its run bit set and moves no word. It continues when the request returns.
- R5: A stop pulse while running clears the run bit on the next edge and sets the software-stop cause (status bit 1).
- R6: A word moved with the end-of-packet marker is still delivered. The run bit then clears on that edge and the end-of-packet cause (status bit 2) is set.
- R7: The budget drops by one per moved word. The channel stops on the edge that moves the word bringing it to zero, which sets the budget cause (status bit 3).
- R8: Every transition from running to idle produces exactly one interrupt pulse, one cycle wide, in the first cycle the run bit reads low. No other interrupt occurs.
- R9: The cause bits stay set while idle until the next accepted start. A stop pulse while idle changes nothing and raises no interrupt.
- R10: When several stop causes occur on the same edge, every one of them is recorded and only one interrupt pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| cnt_load | input | CW | Word budget taken on an accepted start |
| fifo_valid | input | 1 | FIFO holds at least one word |
| fifo_data | input | DW | Word at the FIFO head |
| fifo_eop | input | 1 | End-of-packet marker of the head word |
| fifo_pop | output | 1 | Head word consumed this cycle |
| dev_req | input | 1 | Device request |
| dev_ack | output | 1 | Acknowledge to device |
| dev_wr | output | 1 | Write strobe to device |
| dev_data | output | DW | Word to device |
| status | output | 4 | {budget cause, eop cause, sw cause, run} |
| stop_irq | output | 1 | Stop interrupt pulse |

## Verification
The assertions assume that reset is applied before the first meaningful edge. They also assume that the end-of-packet marker only matters together with a valid FIFO word. The pause property assumes no software stop arrives in the same cycle, so it places the stop input in its antecedent instead of constraining it. The stimulus always loads a nonzero budget, changes inputs only just after a rising edge, and drives the end-of-packet marker only while the FIFO is marked valid. A scoreboard holds every word the driver expects to leave, and a monitor matches each write strobe against it.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
  typedef struct packed {
    logic cnt;
    logic eop;
    logic sw;
  } cause_t;
  localparam int STAT_W = 4;
endpackage

// File: rtl/xdma_count.sv
module xdma_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          dec_en,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_en | dec_en;
    cnt_d  = cnt_q;
    if (load_en)     cnt_d = load_val;
    else if (dec_en) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == ONE);

  assert_dec_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load_en) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/xdma_ctrl.sv
module xdma_ctrl
  import xdma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_req,
  input  logic   stop_req,
  input  logic   ev_eop,
  input  logic   ev_cnt,
  output logic   start_take,
  output logic   run,
  output cause_t cause,
  output logic   irq
);
  logic   run_q, run_d;
  cause_t cause_q, cause_d;
  logic   irq_q, irq_d;
  logic   sw_hit, stop_now;

  always_comb begin
    start_take = start_req & ~run_q;
    sw_hit     = stop_req & run_q;
    stop_now   = run_q & (sw_hit | ev_eop | ev_cnt);
    run_d      = run_q;
    cause_d    = cause_q;
    if (start_take) begin
      run_d   = 1'b1;
      cause_d = '0;
    end else if (stop_now) begin
      run_d       = 1'b0;
      cause_d.sw  = cause_q.sw  | sw_hit;
      cause_d.eop = cause_q.eop | ev_eop;
      cause_d.cnt = cause_q.cnt | ev_cnt;
    end
    irq_d = stop_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      cause_q <= cause_d;
      irq_q   <= irq_d;
    end
  end

  assign run   = run_q;
  assign cause = cause_q;
  assign irq   = irq_q;

  assert_irq_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> irq_q);
  assert_irq_only_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (!run_q && $past(run_q)));
  assert_irq_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cause_q != '0));
  assert_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cause_q == '0));
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_req) |=> (!run_q && $stable(cause_q) && !irq_q));
endmodule

// File: rtl/xdma_drain.sv
module xdma_drain
  import xdma_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic [CW-1:0]     cnt_load,
  input  logic              fifo_valid,
  input  logic [DW-1:0]     fifo_data,
  input  logic              fifo_eop,
  output logic              fifo_pop,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic              dev_wr,
  output logic [DW-1:0]     dev_data,
  output logic [STAT_W-1:0] status,
  output logic              stop_irq
);
  logic   run, start_take, last, xfer;
  cause_t cause;

  assign xfer = run & dev_req & fifo_valid;

  xdma_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (start_take),
    .load_val (cnt_load),
    .dec_en   (xfer),
    .last     (last)
  );

  xdma_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (sw_start),
    .stop_req   (sw_stop),
    .ev_eop     (xfer & fifo_eop),
    .ev_cnt     (xfer & last),
    .start_take (start_take),
    .run        (run),
    .cause      (cause),
    .irq        (stop_irq)
  );

  assign fifo_pop = xfer;
  assign dev_ack  = xfer;
  assign dev_wr   = xfer;
  assign dev_data = fifo_data;
  assign status   = {cause, run};

  assert_pause_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dev_req && !sw_stop) |=> run);
  assert_expire_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last) |=> (!run && status[3]));
  assert_eop_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && fifo_eop) |=> (!run && status[2]));
endmodule

// File: tb/test_xdma_drain.sv
`timescale 1ns/1ps
module test_xdma_drain;
  localparam int DW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sw_start, sw_stop;
  logic [CW-1:0] cnt_load;
  logic          fifo_valid, fifo_eop, dev_req;
  logic [DW-1:0] fifo_data;
  logic          fifo_pop, dev_ack, dev_wr, stop_irq;
  logic [DW-1:0] dev_data;
  logic [3:0]    status;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  xdma_drain #(.DW(DW), .CW(CW)) i_xdma_drain (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_stop(sw_stop),
    .cnt_load(cnt_load), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_eop(fifo_eop), .fifo_pop(fifo_pop), .dev_req(dev_req),
    .dev_ack(dev_ack), .dev_wr(dev_wr), .dev_data(dev_data),
    .status(status), .stop_irq(stop_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each write strobe (R3)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dev_wr) begin
        check("R3 ack with strobe", {31'd0, dev_ack}, 32'd1);
        check("R3 pop with strobe", {31'd0, fifo_pop}, 32'd1);
        if (exp_q.size() == 0) check("R3 unexpected strobe", 32'd1, 32'd0);
        else check("R3 data", {16'd0, dev_data}, {16'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic sync();
    @(posedge clk); #1;
  endtask

  task automatic offer(input logic [DW-1:0] d, input bit e, input bit r, input bit exp_x);
    fifo_valid = 1'b1; fifo_data = d; fifo_eop = e; dev_req = r;
    if (exp_x) exp_q.push_back(d);
    sync();
    fifo_valid = 1'b0; fifo_eop = 1'b0;
  endtask

  task automatic start(input logic [CW-1:0] n);
    sw_start = 1'b1; cnt_load = n;
    sync();
    sw_start = 1'b0;
  endtask

  task automatic stop_pulse();
    sw_stop = 1'b1;
    sync();
    sw_stop = 1'b0;
  endtask

  task automatic sb_empty(input string req);
    check(req, exp_q.size(), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_start = 0; sw_stop = 0; cnt_load = '0;
    fifo_valid = 0; fifo_data = '0; fifo_eop = 0; dev_req = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", {28'd0, status}, 32'd0);
    check("R1 irq", {31'd0, stop_irq}, 32'd0);
    check("R1 ack", {31'd0, dev_ack | dev_wr | fifo_pop}, 32'd0);
    sync();

    // R2, R4, R7: budget of four with a pause in the middle
    start(16'd4);
    @(negedge clk); check("R2 run after start", {28'd0, status}, 32'h1); sync();
    offer(16'hA001, 0, 1, 1);
    offer(16'hA002, 0, 1, 1);
    fifo_valid = 1'b1; fifo_data = 16'hA0FF; dev_req = 1'b0;
    @(negedge clk); check("R4 no ack while req low", {31'd0, dev_ack}, 32'd0); sync();
    @(negedge clk); check("R4 still running", {28'd0, status}, 32'h1); sync();
    fifo_valid = 1'b0;
    offer(16'hA003, 0, 1, 1);
    offer(16'hA004, 0, 1, 1);
    @(negedge clk);
    check("R7 budget stop status", {28'd0, status}, 32'h8);
    check("R8 irq pulse", {31'd0, stop_irq}, 32'd1);
    sync();
    @(negedge clk); check("R8 irq one cycle", {31'd0, stop_irq}, 32'd0); sync();
    sb_empty("R7 all words out");

    // R2: start while running ignored (no reload)
    start(16'd10);
    offer(16'hB000, 0, 1, 1);
    start(16'd100);
    for (int i = 1; i < 9; i++) offer(16'hB000 + 16'(i), 0, 1, 1);
    @(negedge clk); check("R2 running before tenth", {28'd0, status}, 32'h1); sync();
    offer(16'hB009, 0, 1, 1);
    @(negedge clk); check("R2 no reload, stop at ten", {28'd0, status}, 32'h8); sync();
    sb_empty("R2 words out");

    // R5: software stop, then R3 nothing moves when idle
    start(16'd50);
    offer(16'hC001, 0, 1, 1);
    stop_pulse();
    @(negedge clk);
    check("R5 sw stop status", {28'd0, status}, 32'h2);
    check("R8 irq on sw stop", {31'd0, stop_irq}, 32'd1);
    sync();
    fifo_valid = 1'b1; dev_req = 1'b1; fifo_data = 16'hC0FF;
    @(negedge clk); check("R3 no ack while idle", {31'd0, dev_ack}, 32'd0); sync();
    fifo_valid = 1'b0;

    // R9: stop while idle is a no-op, causes stay sticky
    stop_pulse();
    @(negedge clk);
    check("R9 idle stop no irq", {31'd0, stop_irq}, 32'd0);
    check("R9 sticky cause", {28'd0, status}, 32'h2);
    sync();

    // R6, R9: start clears causes, eop ends run
    start(16'd50);
    @(negedge clk); check("R9 causes cleared on start", {28'd0, status}, 32'h1); sync();
    dev_req = 1'b1; fifo_valid = 1'b0;
    @(negedge clk); check("R3 no ack without data", {31'd0, dev_ack}, 32'd0); sync();
    offer(16'hD001, 0, 1, 1);
    offer(16'hD002, 1, 1, 1);
    @(negedge clk);
    check("R6 eop stop status", {28'd0, status}, 32'h4);
    check("R8 irq on eop", {31'd0, stop_irq}, 32'd1);
    sync();
    sb_empty("R6 eop word delivered");

    // R10: all three causes on one edge
    start(16'd3);
    offer(16'hE001, 0, 1, 1);
    offer(16'hE002, 0, 1, 1);
    sw_stop = 1'b1;
    offer(16'hE003, 1, 1, 1);
    sw_stop = 1'b0;
    @(negedge clk);
    check("R10 all causes", {28'd0, status}, 32'hE);
    check("R10 irq", {31'd0, stop_irq}, 32'd1);
    sync();
    @(negedge clk); check("R10 single pulse", {31'd0, stop_irq}, 32'd0); sync();
    sb_empty("R10 words out");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule